// File: doc/BRIEF.md
# PCI Reset and Bus-Parking Output Controller

This block decides, around reset, when a PCI agent drives its shared bus pins and what it drives on them. It covers four groups of pins. The first is the address/data, command/byte-enable and parity group. The second is the transaction strobes (frame, initiator ready, target ready, stop, device select). The third is the two sideband request outputs, memory request and flush request. The fourth is the grant outputs. For each group it produces an output enable, and where needed a value control, that the pad logic uses.

Reset is active low and asynchronous. Its negation passes through a synchronizer. The arbiter-select strap is latched when the synchronized release reaches the state machine, and the latched value is held in `arb_en_o`.

With the arbiter enabled, the bus group is parked low a fixed number of clocks after release. It leaves park when another master is granted, and re-enters park when that grant is withdrawn and the agent is idle. With the arbiter disabled, the bus group floats until the agent itself takes part in a transaction.

The state machine has five states:
- `PK_RESET`: reset, or synchronizer not yet done.
- `PK_WAIT`: extra park delay. It is used only when `PARK_DLY` exceeds `SYNC_STAGES + 1`.
- `PK_PARK`: group driven low.
- `PK_FLOAT`: group undriven.
- `PK_OWN`: agent in a transaction; the group and strobes are enabled, and the values come from the transaction logic.

Its transitions are:
- RESET to PARK or WAIT when the release is seen with the strap high.
- RESET to FLOAT when the release is seen with the strap low.
- WAIT to PARK when the delay count ends.
- PARK to FLOAT on `gnt_other_i`, and PARK to OWN on `agent_busy_i`.
- FLOAT to OWN on `agent_busy_i`, and FLOAT to PARK when the arbiter is enabled with no foreign grant.
- OWN to PARK or FLOAT when `agent_busy_i` falls, chosen by the same park condition.

Top module: `pci_park_ctrl`

## Requirements
- R1: While `rst_n` is low, `bus_oe_o`=1 and `bus_zero_o`=1 (group driven low), and `strb_oe_o`, `gnt_oe_o` and `side_oe_o` are all 0. This takes effect without waiting for a clock edge.
- R2: As soon as `rst_n` goes high, `bus_oe_o` falls to 0 without a clock edge. It stays 0 until parking or a transaction begins.
- R3: `arb_en_o` is 0 during reset. On the 3rd rising edge that samples `rst_n` high, it takes the value of `strap_arb_i` (1 = arbiter enabled). It then holds that value until the next reset.
- R4: With the strap at 1, `bus_zero_o` and `bus_oe_o` become 1 right after the 3rd rising edge that samples `rst_n` high (`PARK_DLY`=3). They are not 1 earlier.
- R5: With the strap at 0, `bus_zero_o` is never 1 after reset release.
- R6: While parked, the first rising edge that samples `gnt_other_i`=1 ends parking: `bus_oe_o`=0 after that edge.
- R7: When not parked and not owning the bus, with the arbiter enabled, an edge that samples `gnt_other_i`=0 and `agent_busy_i`=0 restarts parking.
- R8: After an edge that samples `agent_busy_i`=1, `strb_oe_o`=1, `bus_oe_o`=1 and `bus_zero_o`=0. After an edge that samples it at 0, `strb_oe_o`=0.
- R9: `side_oe_o` equals `rst_n` at all times, without waiting for a clock. When enabled, the sideband requests are driven to their inactive (high) level.
- R10: `gnt_oe_o` becomes 1 after the 2nd rising edge that samples `rst_n` high. While it is 1, `gnt_val_o` equals `arb_gnt_i`; while it is 0, `gnt_val_o` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_arb_i | input | 1 | Arbiter-select strap, latched at release |
| gnt_other_i | input | 1 | Bus granted to another master |
| agent_busy_i | input | 1 | Agent is master or target of a transaction |
| arb_gnt_i | input | N_GNT | Grant values from the arbitration logic |
| bus_oe_o | output | 1 | Enable for address/data, command and parity group |
| bus_zero_o | output | 1 | Force that group to zero |
| strb_oe_o | output | 1 | Enable for transaction strobes |
| side_oe_o | output | 1 | Enable for sideband requests (inactive level) |
| gnt_oe_o | output | 1 | Enable for grant outputs |
| gnt_val_o | output | N_GNT | Grant output values |
| arb_en_o | output | 1 | Latched strap: internal arbiter enabled |

## Verification
The assertions check the following on every cycle:
- the drive state held during reset;
- that no zero is forced with the arbiter disabled;
- that a foreign grant always ends parking on the next edge;
- that strobes are enabled only after the agent was busy;
- that parking never starts before the grant outputs are enabled;
- that the strap is captured on the right edge;
- the grant pass-through.

The exact release timing needs the bench's directed scenarios: the absence of any edge for the sideband and release behaviour, the 3-edge park delay, and the park re-entry sequence. Long random runs compare every output against a reference model, including resets arriving mid-cycle.

// File: rtl/pci_park_pkg.sv
package pci_park_pkg;
    typedef enum logic [2:0] {
        PK_RESET = 3'd0,
        PK_WAIT  = 3'd1,
        PK_PARK  = 3'd2,
        PK_FLOAT = 3'd3,
        PK_OWN   = 3'd4
    } park_state_e;
endpackage

// File: rtl/pci_rel_sync.sv
// Reset-release synchronizer: asserts asynchronously, releases after STAGES edges.
module pci_rel_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic rel_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], 1'b1};
        end
    end

    assign rel_o = chain_q[STAGES-1];
endmodule

// File: rtl/pci_park_fsm.sv
module pci_park_fsm
    import pci_park_pkg::*;
#(
    parameter int PARK_DLY    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rel_i,
    input  logic strap_i,
    input  logic gnt_other_i,
    input  logic busy_i,
    output logic bus_oe_o,
    output logic bus_zero_o,
    output logic strb_oe_o,
    output logic arb_en_o
);
    // Edges left after the synchronizer hands over, before parking begins.
    localparam int WAIT_CYC = PARK_DLY - SYNC_STAGES - 1;
    localparam int CNT_W    = $clog2(PARK_DLY + 1);
    localparam int LAST_CNT = (WAIT_CYC > 0) ? WAIT_CYC - 1 : 0;

    park_state_e state_q, state_d;
    logic [CNT_W-1:0] wait_cnt_q;
    logic park_ok;

    assign park_ok = arb_en_o && !gnt_other_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PK_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PK_RESET: begin
                if (rel_i) begin
                    if (!strap_i)           state_d = PK_FLOAT;
                    else if (WAIT_CYC <= 0) state_d = PK_PARK;
                    else                    state_d = PK_WAIT;
                end
            end
            PK_WAIT: begin
                if (wait_cnt_q == CNT_W'(LAST_CNT)) state_d = PK_PARK;
            end
            PK_PARK: begin
                if (gnt_other_i)  state_d = PK_FLOAT;
                else if (busy_i)  state_d = PK_OWN;
            end
            PK_FLOAT: begin
                if (busy_i)       state_d = PK_OWN;
                else if (park_ok) state_d = PK_PARK;
            end
            PK_OWN: begin
                if (!busy_i)      state_d = park_ok ? PK_PARK : PK_FLOAT;
            end
            default:              state_d = PK_RESET;
        endcase
    end

    // Park delay counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_cnt_q <= '0;
        end else if (state_q == PK_WAIT) begin
            wait_cnt_q <= wait_cnt_q + 1'b1;
        end else begin
            wait_cnt_q <= '0;
        end
    end

    // Strap capture at the synchronized release
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arb_en_o <= 1'b0;
        end else if (state_q == PK_RESET && rel_i) begin
            arb_en_o <= strap_i;
        end
    end

    // Outputs
    always_comb begin
        bus_oe_o   = 1'b0;
        bus_zero_o = 1'b0;
        strb_oe_o  = 1'b0;
        unique case (state_q)
            PK_RESET: begin
                bus_oe_o   = !rst_n;
                bus_zero_o = !rst_n;
            end
            PK_WAIT:  ;
            PK_PARK: begin
                bus_oe_o   = 1'b1;
                bus_zero_o = 1'b1;
            end
            PK_FLOAT: ;
            PK_OWN: begin
                bus_oe_o   = 1'b1;
                strb_oe_o  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pci_gnt_drv.sv
module pci_gnt_drv #(
    parameter int N_GNT = 3
) (
    input  logic             oe_i,
    input  logic [N_GNT-1:0] arb_gnt_i,
    output logic [N_GNT-1:0] gnt_val_o
);
    for (genvar g = 0; g < N_GNT; g++) begin : g_lane
        assign gnt_val_o[g] = oe_i ? arb_gnt_i[g] : 1'b1;
    end
endmodule

// File: rtl/pci_park_ctrl.sv
module pci_park_ctrl #(
    parameter int PARK_DLY    = 3,
    parameter int SYNC_STAGES = 2,
    parameter int N_GNT       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_arb_i,
    input  logic             gnt_other_i,
    input  logic             agent_busy_i,
    input  logic [N_GNT-1:0] arb_gnt_i,
    output logic             bus_oe_o,
    output logic             bus_zero_o,
    output logic             strb_oe_o,
    output logic             side_oe_o,
    output logic             gnt_oe_o,
    output logic [N_GNT-1:0] gnt_val_o,
    output logic             arb_en_o
);
    logic rel;

    pci_rel_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .rel_o (rel)
    );

    pci_park_fsm #(.PARK_DLY(PARK_DLY), .SYNC_STAGES(SYNC_STAGES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rel_i       (rel),
        .strap_i     (strap_arb_i),
        .gnt_other_i (gnt_other_i),
        .busy_i      (agent_busy_i),
        .bus_oe_o    (bus_oe_o),
        .bus_zero_o  (bus_zero_o),
        .strb_oe_o   (strb_oe_o),
        .arb_en_o    (arb_en_o)
    );

    assign gnt_oe_o  = rel;
    // Sideband requests: undriven in reset, driven inactive at once on release.
    assign side_oe_o = rst_n;

    pci_gnt_drv #(.N_GNT(N_GNT)) u_gnt (
        .oe_i      (gnt_oe_o),
        .arb_gnt_i (arb_gnt_i),
        .gnt_val_o (gnt_val_o)
    );
endmodule

// File: rtl/pci_park_chk.sv
module pci_park_chk #(
    parameter int N_GNT = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             strap_arb_i,
    input logic             gnt_other_i,
    input logic             agent_busy_i,
    input logic [N_GNT-1:0] arb_gnt_i,
    input logic             bus_oe_o,
    input logic             bus_zero_o,
    input logic             strb_oe_o,
    input logic             side_oe_o,
    input logic             gnt_oe_o,
    input logic [N_GNT-1:0] gnt_val_o,
    input logic             arb_en_o
);
    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_DRIVE: assert (bus_oe_o && bus_zero_o && !strb_oe_o && !gnt_oe_o && !side_oe_o); // R1
        end
    end

    AST_NO_ZERO_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_en_o |-> !bus_zero_o); // R5

    AST_GRANT_ENDS_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        bus_zero_o && gnt_other_i |=> !bus_zero_o); // R6

    AST_STROBE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strb_oe_o) |-> $past(agent_busy_i)); // R8

    AST_STROBE_OWNS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        strb_oe_o |-> bus_oe_o && !bus_zero_o); // R8

    AST_PARK_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_zero_o) |-> $past(gnt_oe_o)); // R4

    AST_STRAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_oe_o && !$past(gnt_oe_o) |=> arb_en_o == $past(strap_arb_i)); // R3

    AST_GRANT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_oe_o |-> gnt_val_o == arb_gnt_i); // R10
endmodule

bind pci_park_ctrl pci_park_chk #(.N_GNT(N_GNT)) u_chk (.*);

// File: tb/sim_pci_park_ctrl.sv
module sim_pci_park_ctrl;
    localparam int N_GNT = 3;
    localparam int DLY   = 3;
    localparam int M_RST = 0, M_PARK = 2, M_FLOAT = 3, M_OWN = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0, strap = 1'b0, gnt_other = 1'b0, busy = 1'b0;
    logic [N_GNT-1:0] arb_gnt = '0;
    logic bus_oe, bus_zero, strb_oe, side_oe, gnt_oe, arb_en;
    logic [N_GNT-1:0] gnt_val;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    pci_park_ctrl #(.PARK_DLY(DLY), .SYNC_STAGES(2), .N_GNT(N_GNT)) u0 (
        .clk(clk), .rst_n(rst_n), .strap_arb_i(strap), .gnt_other_i(gnt_other),
        .agent_busy_i(busy), .arb_gnt_i(arb_gnt), .bus_oe_o(bus_oe),
        .bus_zero_o(bus_zero), .strb_oe_o(strb_oe), .side_oe_o(side_oe),
        .gnt_oe_o(gnt_oe), .gnt_val_o(gnt_val), .arb_en_o(arb_en)
    );

    // Reference model built from the requirements
    int   m_cnt  = 0;
    int   m_mode = M_RST;
    logic m_arb  = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt <= 0; m_mode <= M_RST; m_arb <= 1'b0;
        end else begin
            m_cnt <= (m_cnt < 7) ? m_cnt + 1 : m_cnt;
            case (m_mode)
                M_RST:   if (m_cnt + 1 == DLY) begin
                             m_arb  <= strap;
                             m_mode <= strap ? M_PARK : M_FLOAT;
                         end
                M_PARK:  if (gnt_other) m_mode <= M_FLOAT;
                         else if (busy) m_mode <= M_OWN;
                M_FLOAT: if (busy) m_mode <= M_OWN;
                         else if (m_arb && !gnt_other) m_mode <= M_PARK;
                M_OWN:   if (!busy) m_mode <= (m_arb && !gnt_other) ? M_PARK : M_FLOAT;
                default: m_mode <= M_RST;
            endcase
        end
    end

    function automatic logic exp_bus_oe();
        return (m_mode == M_RST) ? !rst_n : (m_mode == M_PARK || m_mode == M_OWN);
    endfunction
    function automatic logic exp_zero();
        return (m_mode == M_RST) ? !rst_n : (m_mode == M_PARK);
    endfunction
    function automatic logic exp_gnt_oe();
        return rst_n && (m_cnt >= 2);
    endfunction
    function automatic logic [N_GNT-1:0] exp_gnt_val();
        return exp_gnt_oe() ? arb_gnt : '1;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_model();
        chk("R1/R2/R4/R8", "bus_oe", 32'(bus_oe), 32'(exp_bus_oe()));
        chk("R1/R4/R5/R6/R7", "bus_zero", 32'(bus_zero), 32'(exp_zero()));
        chk("R8", "strb_oe", 32'(strb_oe), 32'(m_mode == M_OWN));
        chk("R9", "side_oe", 32'(side_oe), 32'(rst_n));
        chk("R10", "gnt_oe", 32'(gnt_oe), 32'(exp_gnt_oe()));
        chk("R10", "gnt_val", 32'(gnt_val), 32'(exp_gnt_val()));
        chk("R3", "arb_en", 32'(arb_en), 32'(m_arb));
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int rst_left;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "bus_oe", 32'(bus_oe), 1); chk("R1", "bus_zero", 32'(bus_zero), 1);
        chk("R1", "strb_oe", 32'(strb_oe), 0); chk("R1", "gnt_oe", 32'(gnt_oe), 0);
        chk("R9", "side_oe", 32'(side_oe), 0);
        // Release with arbiter enabled
        strap = 1'b1; arb_gnt = 3'b101;
        rst_n = 1'b1;
        #1;
        chk("R9", "side_oe async", 32'(side_oe), 1);
        chk("R2", "bus_oe released", 32'(bus_oe), 0);
        chk("R10", "gnt_val idle", 32'(gnt_val), 32'h7);
        @(negedge clk);
        chk("R4", "no early park e1", 32'(bus_zero), 0);
        chk("R10", "gnt_oe e1", 32'(gnt_oe), 0);
        @(negedge clk);
        chk("R4", "no early park e2", 32'(bus_zero), 0);
        chk("R10", "gnt_oe e2", 32'(gnt_oe), 1);
        chk("R10", "gnt_val follows", 32'(gnt_val), 32'h5);
        @(negedge clk);
        chk("R4", "park e3", 32'(bus_zero & bus_oe), 1);
        chk("R3", "strap high", 32'(arb_en), 1);
        gnt_other = 1'b1;
        @(negedge clk);
        chk("R6", "park ends", 32'(bus_oe), 0);
        gnt_other = 1'b0;
        @(negedge clk);
        chk("R7", "park resumes", 32'(bus_zero), 1);
        busy = 1'b1;
        @(negedge clk);
        chk("R8", "strobes on", 32'(strb_oe), 1);
        chk("R8", "bus owned", 32'({bus_oe, bus_zero}), 32'h2);
        busy = 1'b0;
        @(negedge clk);
        chk("R8", "strobes off", 32'(strb_oe), 0);
        chk("R7", "park after own", 32'(bus_zero), 1);
        // Mid-cycle reset, then arbiter disabled
        @(posedge clk); #3;
        rst_n = 1'b0; strap = 1'b0;
        #1;
        chk("R1", "async drive low", 32'({bus_oe, bus_zero, strb_oe, gnt_oe}), 32'hC);
        chk("R9", "side float", 32'(side_oe), 0);
        chk("R3", "arb cleared", 32'(arb_en), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3", "strap low", 32'(arb_en), 0);
        chk("R5", "no park", 32'(bus_oe), 0);
        for (int i = 0; i < 20; i++) begin
            gnt_other = 1'($urandom % 2);
            @(negedge clk);
            chk("R5", "stays floating", 32'(bus_zero), 0);
        end
        busy = 1'b1;
        @(negedge clk);
        chk("R8", "own when disabled", 32'({bus_oe, strb_oe}), 32'h3);
        busy = 1'b0;
        @(negedge clk);
        chk("R5", "float after own", 32'(bus_oe), 0);
        // Random phase against the model
        rst_left = 0;
        for (int c = 0; c < 6000; c++) begin
            @(negedge clk);
            chk_model();
            gnt_other = ($urandom % 4) == 0;
            busy      = ($urandom % 5) == 0;
            arb_gnt   = N_GNT'($urandom);
            if (rst_left > 0) begin
                rst_left--;
                if (rst_left == 0) rst_n = 1'b1;
            end else if ($urandom % 300 == 0) begin
                rst_n    = 1'b0;
                strap    = 1'($urandom % 2);
                rst_left = 2 + ($urandom % 4);
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule